// File: doc/BRIEF.md
# Saturating Dword-to-Word Vector Packer

This unit narrows two vectors of signed 32-bit elements into one vector of unsigned 16-bit elements. Each element is clamped to the unsigned 16-bit range. Results are arranged per 128-bit lane: the four clamped dwords of the first source come first, then the four of the second source from the same lane. A vector-length select chooses 128, 256 or 512 bits. The second source can be replaced by one 32-bit value repeated across all its elements. A per-word write mask lets each result word either merge with the previous destination or be zeroed.

A compatibility mode limits the operation to the low 128 bits. In this mode the previous destination acts as the first source, and the destination bits above bit 127 keep their prior contents. Inputs are accepted on a valid strobe, and the packed destination is registered with an output valid one clock later.

Top module: `sat_pack_unit`

## Requirements
- R1: Each signed 32-bit element becomes 0x0000 if negative, 0xFFFF if above 0xFFFF, else its low 16 bits; 0x0000FFFF, 0x00010000, 0xFFFFFFFF and 0x80000000 give 0xFFFF, 0xFFFF, 0x0000, 0x0000.
- R2: In lane L, result words 8L+0..8L+3 come from first-source dwords 4L+0..4L+3 and words 8L+4..8L+7 from second-source dwords 4L+0..4L+3, in order; word w occupies dest bits [16w+15:16w].
- R3: `vlen_i` 2'b00 selects 8 live words, 2'b01 selects 16, 2'b10 and 2'b11 select 32; outside legacy mode, dest words beyond the live count are zero.
- R4: With `bcast_i` high (outside legacy mode), every second-source dword is taken as `src_b_i[31:0]`.
- R5: With `mask_en_i` high and `zero_mode_i` low, a live word whose `mask_i` bit is 0 takes the matching word of `dest_old_i`; a word whose bit is 1 takes the packed value.
- R6: With `mask_en_i` and `zero_mode_i` high, a live word whose `mask_i` bit is 0 is zero.
- R7: Mask bits at or above the live word count have no effect, and with `mask_en_i` low every live word is written with the packed value.
- R8: With `legacy_i` high, the first source is `dest_old_i[127:0]` (`src_a_i` is unused), 8 words are live, mask and broadcast and `vlen_i` are ignored, and dest bits 511:128 equal `dest_old_i[511:128]`.
- R9: The result of an accepted input appears on `dest_o` with `out_valid_o` high on the next clock; `out_valid_o` is low after a cycle without `in_valid_i`, and `dest_o` holds its value then.
- R10: While `rst_ni` is low, `out_valid_o` and `dest_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| src_a_i | input | 512 | First source, 16 signed dwords |
| src_b_i | input | 512 | Second source, 16 signed dwords |
| bcast_i | input | 1 | Repeat src_b_i[31:0] over the second source |
| vlen_i | input | 2 | Vector length select |
| mask_en_i | input | 1 | Write mask active |
| zero_mode_i | input | 1 | 1: masked words zeroed, 0: merged |
| mask_i | input | 32 | Per-result-word mask |
| dest_old_i | input | 512 | Previous destination value |
| legacy_i | input | 1 | 128-bit compatibility mode |
| out_valid_o | output | 1 | Result valid |
| dest_o | output | 512 | Packed destination |

## Verification
The unit holds only the result register and the valid flag. A fault therefore appears on `dest_o` in the cycle right after the affected input is accepted. If a hold cycle lets the value drift, the fault shows in the first idle cycle. A lane routed to the wrong place or a wrong clamp threshold corrupts particular 16-bit words, so the checker compares the whole vector against a model on every clock. Boundary dwords, distinct per-dword values and masks with bits set above the live count are used to catch swaps that random data would hide.

// File: rtl/sat_pack_pkg.sv
package sat_pack_pkg;
  typedef enum logic [1:0] {
    VL_128  = 2'b00,
    VL_256  = 2'b01,
    VL_512  = 2'b10,
    VL_512X = 2'b11
  } vlen_e;

  // lanes enabled for a length code, clipped to what the build has
  function automatic int unsigned live_lanes(vlen_e v, int unsigned max_lanes);
    int unsigned n;
    case (v)
      VL_128:  n = 1;
      VL_256:  n = 2;
      default: n = 4;
    endcase
    return (n > max_lanes) ? max_lanes : n;
  endfunction
endpackage

// File: rtl/sat_pack_clamp.sv
module sat_pack_clamp #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] res_o
);
  logic neg, over;
  assign neg  = val_i[IN_W-1];
  assign over = |val_i[IN_W-2:OUT_W];

  always_comb begin
    if (neg)       res_o = '0;
    else if (over) res_o = '1;
    else           res_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/sat_pack_lane.sv
module sat_pack_lane #(
  parameter int unsigned ELEM_W = 32,
  parameter int unsigned RES_W  = 16,
  parameter int unsigned LANE_W = 128,
  localparam int unsigned DW_N  = LANE_W / ELEM_W,
  localparam int unsigned OUT_W = 2 * DW_N * RES_W
) (
  input  logic [LANE_W-1:0] a_lane_i,
  input  logic [LANE_W-1:0] b_lane_i,
  output logic [OUT_W-1:0]  packed_o
);
  for (genvar k = 0; k < DW_N; k++) begin : g_dw
    sat_pack_clamp #(.IN_W(ELEM_W), .OUT_W(RES_W)) u_clamp_a (
      .val_i(a_lane_i[k*ELEM_W +: ELEM_W]),
      .res_o(packed_o[k*RES_W +: RES_W])
    );
    sat_pack_clamp #(.IN_W(ELEM_W), .OUT_W(RES_W)) u_clamp_b (
      .val_i(b_lane_i[k*ELEM_W +: ELEM_W]),
      .res_o(packed_o[(k+DW_N)*RES_W +: RES_W])
    );
  end
endmodule

// File: rtl/sat_pack_wmask.sv
module sat_pack_wmask #(
  parameter int unsigned NUM_WORDS = 32,
  parameter int unsigned RES_W     = 16,
  localparam int unsigned VEC_W    = NUM_WORDS * RES_W
) (
  input  logic [VEC_W-1:0]     packed_i,
  input  logic [VEC_W-1:0]     old_i,
  input  logic [NUM_WORDS-1:0] live_i,
  input  logic [NUM_WORDS-1:0] mask_i,
  input  logic                 mask_en_i,
  input  logic                 zero_mode_i,
  input  logic                 legacy_i,
  output logic [VEC_W-1:0]     res_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [RES_W-1:0] pk, od;
    logic             wr;
    assign pk = packed_i[w*RES_W +: RES_W];
    assign od = old_i[w*RES_W +: RES_W];
    assign wr = legacy_i | ~mask_en_i | mask_i[w];

    always_comb begin
      if (!live_i[w])       res_o[w*RES_W +: RES_W] = legacy_i ? od : '0;
      else if (wr)          res_o[w*RES_W +: RES_W] = pk;
      else if (zero_mode_i) res_o[w*RES_W +: RES_W] = '0;
      else                  res_o[w*RES_W +: RES_W] = od;
    end
  end
endmodule

// File: rtl/sat_pack_unit.sv
module sat_pack_unit
  import sat_pack_pkg::*;
#(
  parameter int unsigned MAX_VL = 512,
  parameter int unsigned ELEM_W = 32,
  parameter int unsigned RES_W  = 16,
  parameter int unsigned LANE_W = 128,
  localparam int unsigned NUM_LANES = MAX_VL / LANE_W,
  localparam int unsigned WPL       = 2 * LANE_W / ELEM_W,
  localparam int unsigned NUM_WORDS = NUM_LANES * WPL,
  localparam int unsigned DW_N      = MAX_VL / ELEM_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [MAX_VL-1:0]    src_a_i,
  input  logic [MAX_VL-1:0]    src_b_i,
  input  logic                 bcast_i,
  input  logic [1:0]           vlen_i,
  input  logic                 mask_en_i,
  input  logic                 zero_mode_i,
  input  logic [NUM_WORDS-1:0] mask_i,
  input  logic [MAX_VL-1:0]    dest_old_i,
  input  logic                 legacy_i,
  output logic                 out_valid_o,
  output logic [MAX_VL-1:0]    dest_o
);
  logic [MAX_VL-1:0]    a_eff, b_eff, packed_v, next_v;
  logic [NUM_WORDS-1:0] live;
  int unsigned          n_lanes;

  // legacy: destination doubles as first source
  assign a_eff = legacy_i ? {src_a_i[MAX_VL-1:LANE_W], dest_old_i[LANE_W-1:0]} : src_a_i;

  for (genvar d = 0; d < DW_N; d++) begin : g_bsel
    assign b_eff[d*ELEM_W +: ELEM_W] = (bcast_i && !legacy_i) ? src_b_i[ELEM_W-1:0]
                                                             : src_b_i[d*ELEM_W +: ELEM_W];
  end

  assign n_lanes = legacy_i ? 1 : live_lanes(vlen_e'(vlen_i), NUM_LANES);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    sat_pack_lane #(.ELEM_W(ELEM_W), .RES_W(RES_W), .LANE_W(LANE_W)) u_lane (
      .a_lane_i(a_eff[l*LANE_W +: LANE_W]),
      .b_lane_i(b_eff[l*LANE_W +: LANE_W]),
      .packed_o(packed_v[l*WPL*RES_W +: WPL*RES_W])
    );
    assign live[l*WPL +: WPL] = {WPL{l < n_lanes}};
  end

  sat_pack_wmask #(.NUM_WORDS(NUM_WORDS), .RES_W(RES_W)) u_wmask (
    .packed_i   (packed_v),
    .old_i      (dest_old_i),
    .live_i     (live),
    .mask_i     (mask_i),
    .mask_en_i  (mask_en_i),
    .zero_mode_i(zero_mode_i),
    .legacy_i   (legacy_i),
    .res_o      (next_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      dest_o      <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) dest_o <= next_v;
    end
  end
endmodule

// File: rtl/sat_pack_chk.sv
module sat_pack_chk #(
  parameter int unsigned MAX_VL    = 512,
  parameter int unsigned LANE_W    = 128,
  parameter int unsigned NUM_WORDS = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic [1:0]           vlen_i,
  input logic                 mask_en_i,
  input logic                 zero_mode_i,
  input logic [NUM_WORDS-1:0] mask_i,
  input logic [MAX_VL-1:0]    dest_old_i,
  input logic                 legacy_i,
  input logic                 out_valid_o,
  input logic [MAX_VL-1:0]    dest_o
);
  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R9
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(dest_o)));
  // R3
  upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !legacy_i && vlen_i == 2'b00) |=> (dest_o[MAX_VL-1:LANE_W] == '0));
  // R8
  legacy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && legacy_i) |=> (dest_o[MAX_VL-1:LANE_W] == $past(dest_old_i[MAX_VL-1:LANE_W])));
  // R6
  zero_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !legacy_i && mask_en_i && zero_mode_i && mask_i == '0) |=> (dest_o == '0));
  // R5
  merge_word0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !legacy_i && mask_en_i && !zero_mode_i && !mask_i[0])
      |=> (dest_o[15:0] == $past(dest_old_i[15:0])));
endmodule

bind sat_pack_unit sat_pack_chk #(.MAX_VL(MAX_VL), .LANE_W(LANE_W), .NUM_WORDS(NUM_WORDS)) chk_i (.*);

// File: tb/sat_pack_unit_tb.sv
module sat_pack_unit_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [511:0] src_a_i = '0, src_b_i = '0, dest_old_i = '0;
  logic         bcast_i = 1'b0, mask_en_i = 1'b0, zero_mode_i = 1'b0, legacy_i = 1'b0;
  logic [1:0]   vlen_i = 2'b00;
  logic [31:0]  mask_i = '0;
  logic         out_valid_o;
  logic [511:0] dest_o;

  int    n_cmp = 0, n_bad = 0;
  bit    run_chk = 1'b0, done = 1'b0;
  string cur_tag = "R9", exp_tag = "R10";
  logic         exp_valid = 1'b0;
  logic [511:0] exp_dest = '0;

  always #10 clk_i = ~clk_i;

  sat_pack_unit dut_i (.*);

  function automatic logic [511:0] ref_pack(
    input logic [511:0] a, input logic [511:0] b, input logic [511:0] old,
    input bit bc, input logic [1:0] vl, input bit me, input bit zm,
    input logic [31:0] m, input bit leg);
    logic [511:0] r;
    logic [31:0]  d;
    logic [15:0]  q;
    int live, s;
    r = '0;
    live = leg ? 8 : (vl == 2'b00 ? 8 : (vl == 2'b01 ? 16 : 32));
    for (int w = 0; w < 32; w++) begin
      int lane, k;
      lane = w / 8;
      k = w % 8;
      if (k < 4) d = (leg && lane == 0) ? old[k*32 +: 32] : a[(lane*4+k)*32 +: 32];
      else       d = (bc && !leg) ? b[31:0] : b[(lane*4+k-4)*32 +: 32];
      s = $signed(d);
      if (s < 0)          q = 16'h0000;
      else if (s > 65535) q = 16'hFFFF;
      else                q = d[15:0];
      if (w >= live)                  r[w*16 +: 16] = leg ? old[w*16 +: 16] : 16'h0;
      else if (!leg && me && !m[w])   r[w*16 +: 16] = zm ? 16'h0 : old[w*16 +: 16];
      else                            r[w*16 +: 16] = q;
    end
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_valid <= 1'b0;
      exp_dest  <= '0;
    end else begin
      exp_valid <= in_valid_i;
      exp_tag   <= in_valid_i ? cur_tag : "R9";
      if (in_valid_i)
        exp_dest <= ref_pack(src_a_i, src_b_i, dest_old_i, bcast_i, vlen_i,
                             mask_en_i, zero_mode_i, mask_i, legacy_i);
    end
  end

  always @(negedge clk_i) begin
    if (run_chk && !done) begin
      n_cmp++;
      if (out_valid_o !== exp_valid || dest_o !== exp_dest) begin
        n_bad++;
        $display("FAIL %s: valid=%0b dest=%h expected valid=%0b dest=%h",
                 exp_tag, out_valid_o, dest_o, exp_valid, exp_dest);
      end
    end
  end

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic issue(input string tag, input logic [511:0] a, input logic [511:0] b,
                       input logic [511:0] old, input bit bc, input logic [1:0] vl,
                       input bit me, input bit zm, input logic [31:0] m, input bit leg);
    @(negedge clk_i);
    #2;
    cur_tag = tag; src_a_i = a; src_b_i = b; dest_old_i = old; bcast_i = bc;
    vlen_i = vl; mask_en_i = me; zero_mode_i = zm; mask_i = m; legacy_i = leg;
    in_valid_i = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      #2;
      in_valid_i = 1'b0;
      src_a_i = rnd512(); dest_old_i = rnd512();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL R9: watchdog expired, actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [511:0] a, b, ones;
    ones = '1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10: outputs zero in reset
    n_cmp++;
    if (out_valid_o !== 1'b0 || dest_o !== '0) begin
      n_bad++;
      $display("FAIL R10: valid=%0b dest=%h expected valid=0 dest=0", out_valid_o, dest_o);
    end
    #2 rst_ni = 1'b1;
    run_chk = 1'b1;
    idle(2);

    // R1: saturation boundaries
    a = '0; b = '0;
    a[127:0] = {32'h80000000, 32'hFFFFFFFF, 32'h00010000, 32'h0000FFFF};
    b[127:0] = {32'h7FFFFFFF, 32'h00000000, 32'h00001234, 32'h00000007};
    issue("R1", a, b, ones, 0, 2'b00, 0, 0, 32'h0, 0);
    idle(1);

    // R2: distinct dwords expose ordering across all lanes
    for (int i = 0; i < 16; i++) begin
      a[i*32 +: 32] = i*3 + 1;
      b[i*32 +: 32] = 32'h100 + i;
    end
    issue("R2", a, b, '0, 0, 2'b10, 0, 0, 32'h0, 0);
    issue("R2", b, a, ones, 0, 2'b11, 0, 0, 32'h0, 0);
    idle(1);

    // R3: every length code, stale dest all ones
    for (int v = 0; v < 4; v++) issue("R3", rnd512(), rnd512(), ones, 0, v[1:0], 0, 0, 32'h0, 0);
    idle(1);

    // R4: broadcast of positive, negative and large values
    b = rnd512(); b[31:0] = 32'h0000ABCD;
    issue("R4", rnd512(), b, '0, 1, 2'b10, 0, 0, 32'h0, 0);
    b[31:0] = 32'hFFFF0001;
    issue("R4", rnd512(), b, '0, 1, 2'b01, 0, 0, 32'h0, 0);
    b[31:0] = 32'h00020000;
    issue("R4", rnd512(), b, '0, 1, 2'b00, 0, 0, 32'h0, 0);

    // R5: merge masking
    issue("R5", rnd512(), rnd512(), rnd512(), 0, 2'b10, 1, 0, 32'hA5C3_0F96, 0);
    issue("R5", rnd512(), rnd512(), rnd512(), 0, 2'b10, 1, 0, 32'h0, 0);
    // R6: zero masking
    issue("R6", rnd512(), rnd512(), rnd512(), 0, 2'b10, 1, 1, 32'h5A3C_F069, 0);
    issue("R6", rnd512(), rnd512(), rnd512(), 0, 2'b01, 1, 1, 32'h0, 0);
    idle(1);

    // R7: high mask bits ignored, mask disabled writes all
    issue("R7", rnd512(), rnd512(), rnd512(), 0, 2'b00, 1, 0, 32'hFFFF_FF00, 0);
    issue("R7", rnd512(), rnd512(), rnd512(), 0, 2'b01, 1, 1, 32'hFFFF_0000, 0);
    issue("R7", rnd512(), rnd512(), rnd512(), 0, 2'b10, 0, 1, 32'h0, 0);

    // R8: legacy mode ignores src_a, mask, broadcast and length
    issue("R8", rnd512(), rnd512(), rnd512(), 1, 2'b10, 1, 1, 32'h0, 1);
    issue("R8", rnd512(), rnd512(), rnd512(), 0, 2'b01, 1, 0, 32'h0, 1);
    idle(2);

    // R9: mixed traffic with gaps
    for (int t = 0; t < 300; t++) begin
      issue("R9", rnd512(), rnd512(), rnd512(), $urandom_range(0, 1) == 1,
            2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1, $urandom, $urandom_range(0, 5) == 0);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(3);
    summary();
  end
endmodule